// File: doc/BRIEF.md
# Shadow RAM Region Mapper

The mapper routes each CPU memory cycle that falls in the upper-memory area of the first megabyte. Two shadowable windows exist: a lower one from 0A0000h to 0BFFFFh and a main one from 0C0000h to 0FFFFFh. Both are split into 16 KB sub-regions. For each cycle the block asserts exactly one of three outcomes: the boot ROM chip-select, the DRAM select, or neither, which leaves the cycle to some other device. It also drives a write-inhibit that lets a write complete on the bus while the DRAM write strobes are held off.

Software sets the routing through an index/data register pair. Three shadow-enable registers hold one bit per 16 KB sub-region. A ROM-enable register gates the ROM select for each 64 KB segment of the main window. A lock register makes shadowed segments read-only. The outputs are combinational from the cycle inputs and the registered configuration, so a register written in one cycle steers the bus cycle in the next. Software can therefore switch between ROM and shadow while it copies firmware into DRAM block by block.

Top module: `shadow_region_mapper`

## Requirements
- R1: After reset the ROM-enable register is 0Fh, the shadow-enable registers are 00h and the lock register is 00h. A read in the main window then asserts `rom_cs` only.
- R2: A valid cycle whose address lies outside both windows asserts `dram_sel`. It never asserts `rom_cs` or `wr_inhibit`, whatever the configuration.
- R3: A valid cycle to an unshadowed main-window sub-region whose ROM-enable bit is set asserts `rom_cs` and not `dram_sel`, for both reads and writes. ROM-enable bits 0..3 cover the 64 KB segments at 0C0000h, 0D0000h, 0E0000h and 0F0000h.
- R4: With the segment's ROM-enable bit clear and the sub-region unshadowed, a main-window cycle asserts none of the three outputs.
- R5: Shadow bit k of the register at index 4Ah, 4Bh or 4Ch covers the 16 KB sub-region at 0A0000h, 0C0000h or 0E0000h plus k*4000h. When that bit is set, a cycle there asserts `dram_sel` and never `rom_cs`, whatever the ROM-enable bit.
- R6: An unshadowed cycle in the lower window never asserts `rom_cs` and asserts none of the outputs.
- R7: Lock bit j of the register at index 49h covers the 64 KB segment at 0A0000h + j*10000h, for j = 0..5. A write to a shadowed sub-region of a locked segment asserts `dram_sel` and `wr_inhibit`. A read there asserts `dram_sel` without `wr_inhibit`. Unlocked segments never inhibit.
- R8: The lock has no effect on unshadowed sub-regions: `wr_inhibit` stays low for them.
- R9: With `cfg_port` = 0 a write loads the index. With `cfg_port` = 1 a write loads the register named by the held index and leaves the index unchanged. Data writes to indices other than 48h, 49h and 4Ah..4Ch change nothing.
- R10: A data write that completes on one clock edge decides the routing of the cycle that follows that edge.
- R11: When `cyc_valid` is low, `rom_cs`, `dram_sel` and `wr_inhibit` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_port | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wdata | input | 8 | Configuration write data |
| cyc_valid | input | 1 | A memory cycle is present this clock |
| cyc_wr | input | 1 | 1 for a write cycle, 0 for a read |
| cyc_addr | input | 24 | Cycle byte address |
| rom_cs | output | 1 | Boot ROM chip-select |
| dram_sel | output | 1 | DRAM select |
| wr_inhibit | output | 1 | Suppress DRAM write strobes for this cycle |

## Verification
The embedded properties check, on every clock, that idle cycles stay quiet and that addresses outside the windows always go to DRAM. They also check that ROM and DRAM are never selected together, that the lower window never reaches ROM, and that the inhibit appears only on DRAM writes. The register port's properties cover index retention, ignored indices and the one-cycle latency of a register update. The mapping of each shadow and lock bit to its own address range can only be shown by the bench's scenarios. The same holds for the ROM-enable gating, the priority of shadow over ROM, and the alternation of settings during a copy. In those scenarios a behavioural model is compared with the outputs on every cycle.

// File: rtl/smr_pkg.sv
package smr_pkg;

   typedef enum logic {
      PORT_INDEX = 1'b0,
      PORT_DATA  = 1'b1
   } cfg_port_e;

   typedef struct packed {
      logic in_low;
      logic in_main;
   } window_hit_t;

endpackage

// File: rtl/smr_cfg_regs.sv
module smr_cfg_regs #(
   parameter int IDX_W           = 8,
   parameter int DATA_W          = 8,
   parameter int IDX_ROM_EN      = 'h48,
   parameter int IDX_LOCK        = 'h49,
   parameter int IDX_SHADOW_BASE = 'h4A,
   parameter int N_SHADOW_REGS   = 3,
   parameter int N_ROM_SEG       = 4,
   parameter int N_SEG           = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_wr,
   input  logic                              cfg_port,
   input  logic [DATA_W-1:0]                 cfg_wdata,
   output logic [N_ROM_SEG-1:0]              rom_en,
   output logic [N_SEG-1:0]                  ro_lock,
   output logic [N_SHADOW_REGS*DATA_W-1:0]   shadow_en
);
   import smr_pkg::*;

   localparam int SHADOW_LAST = IDX_SHADOW_BASE + N_SHADOW_REGS - 1;

   if (IDX_W > DATA_W) begin : g_bad_idx_w
      $error("smr_cfg_regs: index wider than data port");
   end
   if (N_ROM_SEG > DATA_W || N_SEG > DATA_W) begin : g_bad_seg
      $error("smr_cfg_regs: segment count exceeds register width");
   end
   if (SHADOW_LAST >= (1 << IDX_W)) begin : g_bad_range
      $error("smr_cfg_regs: shadow registers exceed index space");
   end

   logic [IDX_W-1:0] idx_q;
   logic             idx_wr;
   logic             data_wr;
   logic             hit_rom;
   logic             hit_lock;
   logic             hit_shadow;

   assign idx_wr     = cfg_wr && (cfg_port_e'(cfg_port) == PORT_INDEX);
   assign data_wr    = cfg_wr && (cfg_port_e'(cfg_port) == PORT_DATA);
   assign hit_rom    = data_wr && (idx_q == IDX_W'(IDX_ROM_EN));
   assign hit_lock   = data_wr && (idx_q == IDX_W'(IDX_LOCK));
   assign hit_shadow = data_wr && (idx_q >= IDX_W'(IDX_SHADOW_BASE))
                               && (idx_q <= IDX_W'(SHADOW_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (idx_wr) begin
         idx_q <= cfg_wdata[IDX_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_en <= '1;
      end else if (hit_rom) begin
         rom_en <= cfg_wdata[N_ROM_SEG-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ro_lock <= '0;
      end else if (hit_lock) begin
         ro_lock <= cfg_wdata[N_SEG-1:0];
      end
   end

   for (genvar g = 0; g < N_SHADOW_REGS; g++) begin : g_shadow
      logic             sel;
      logic [DATA_W-1:0] sh_q;

      assign sel = data_wr && (idx_q == IDX_W'(IDX_SHADOW_BASE + g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else if (sel) begin
            sh_q <= cfg_wdata;
         end
      end

      assign shadow_en[g*DATA_W +: DATA_W] = sh_q;
   end

   // R9: a data-port write leaves the held index alone
   a_r9_index_held: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> $stable(idx_q));

   // R9: data writes to unknown indices change no register
   a_r9_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !hit_rom && !hit_lock && !hit_shadow)
         |=> ($stable(rom_en) && $stable(ro_lock) && $stable(shadow_en)));

   // R10: the lock register holds the written value in the next cycle
   a_r10_lock_lands: assert property (@(posedge clk) disable iff (!rst_n)
      hit_lock |=> (ro_lock == $past(cfg_wdata[N_SEG-1:0])));

   // R10: the ROM-enable register holds the written value in the next cycle
   a_r10_rom_lands: assert property (@(posedge clk) disable iff (!rst_n)
      hit_rom |=> (rom_en == $past(cfg_wdata[N_ROM_SEG-1:0])));

endmodule

// File: rtl/smr_addr_decode.sv
module smr_addr_decode #(
   parameter int ADDR_W    = 24,
   parameter int SUB_LOG2  = 14,
   parameter int SEG_LOG2  = 16,
   parameter int LOW_BASE  = 'hA0000,
   parameter int LOW_LOG2  = 17,
   parameter int MAIN_BASE = 'hC0000,
   parameter int MAIN_LOG2 = 18,
   parameter int SUB_W     = 5,
   parameter int SEG_W     = 3
) (
   input  logic [ADDR_W-1:0]   addr,
   output smr_pkg::window_hit_t hit,
   output logic [SUB_W-1:0]    sub_idx,
   output logic [SEG_W-1:0]    seg_idx
);
   localparam int N_SUB_LOW  = 1 << (LOW_LOG2 - SUB_LOG2);
   localparam int N_SUB_MAIN = 1 << (MAIN_LOG2 - SUB_LOG2);
   localparam int SEG_SHIFT  = SEG_LOG2 - SUB_LOG2;

   if (SEG_LOG2 < SUB_LOG2 || SEG_LOG2 > LOW_LOG2) begin : g_bad_seg
      $error("smr_addr_decode: segment size must lie between sub-region and window");
   end
   if ((LOW_BASE % (1 << LOW_LOG2)) != 0 || (MAIN_BASE % (1 << MAIN_LOG2)) != 0) begin : g_bad_align
      $error("smr_addr_decode: window bases must be aligned to their size");
   end
   if (LOW_BASE + (1 << LOW_LOG2) > MAIN_BASE) begin : g_bad_order
      $error("smr_addr_decode: lower window must end before main window");
   end
   if ((1 << SUB_W) < N_SUB_LOW + N_SUB_MAIN) begin : g_bad_sub_w
      $error("smr_addr_decode: sub-region index too narrow");
   end

   logic [ADDR_W-1:0] sub_field;
   logic [SUB_W-1:0]  low_off;
   logic [SUB_W-1:0]  main_off;

   assign sub_field = addr >> SUB_LOG2;
   assign low_off   = SUB_W'(sub_field & ADDR_W'(N_SUB_LOW - 1));
   assign main_off  = SUB_W'(sub_field & ADDR_W'(N_SUB_MAIN - 1));

   always_comb begin
      hit.in_low  = (addr >> LOW_LOG2)  == ADDR_W'(LOW_BASE  >> LOW_LOG2);
      hit.in_main = (addr >> MAIN_LOG2) == ADDR_W'(MAIN_BASE >> MAIN_LOG2);
      if (hit.in_main) begin
         sub_idx = SUB_W'(N_SUB_LOW) + main_off;
      end else begin
         sub_idx = low_off;
      end
      seg_idx = SEG_W'(sub_idx >> SEG_SHIFT);
   end

endmodule

// File: rtl/smr_route.sv
module smr_route #(
   parameter int N_SUB            = 24,
   parameter int SUB_W            = 5,
   parameter int N_SEG            = 6,
   parameter int SEG_W            = 3,
   parameter int N_LOW_SEG        = 2,
   parameter int N_ROM_SEG        = 4,
   parameter bit ROM_SEL_ON_WRITE = 1'b1
) (
   input  logic                 cyc_valid,
   input  logic                 cyc_wr,
   input  smr_pkg::window_hit_t hit,
   input  logic [SUB_W-1:0]     sub_idx,
   input  logic [SEG_W-1:0]     seg_idx,
   input  logic [N_SUB-1:0]     shadow_en,
   input  logic [N_SEG-1:0]     ro_lock,
   input  logic [N_ROM_SEG-1:0] rom_en,
   output logic                 rom_cs,
   output logic                 dram_sel,
   output logic                 wr_inhibit
);
   localparam int ROM_W = (N_ROM_SEG > 1) ? $clog2(N_ROM_SEG) : 1;

   logic             in_any;
   logic             shadowed;
   logic             locked;
   logic [SEG_W-1:0] rom_seg;
   logic             rom_on;
   logic             rom_dir_ok;

   if (ROM_SEL_ON_WRITE) begin : g_rom_rw
      assign rom_dir_ok = 1'b1;
   end else begin : g_rom_rd_only
      assign rom_dir_ok = !cyc_wr;
   end

   always_comb begin
      in_any     = hit.in_low || hit.in_main;
      shadowed   = in_any && shadow_en[sub_idx];
      locked     = ro_lock[seg_idx];
      rom_seg    = seg_idx - SEG_W'(N_LOW_SEG);
      rom_on     = hit.in_main && rom_en[rom_seg[ROM_W-1:0]];
      rom_cs     = cyc_valid && !shadowed && rom_on && rom_dir_ok;
      dram_sel   = cyc_valid && (shadowed || !in_any);
      wr_inhibit = cyc_valid && cyc_wr && shadowed && locked;
   end

endmodule

// File: rtl/shadow_region_mapper.sv
module shadow_region_mapper #(
   parameter int ADDR_W           = 24,
   parameter int DATA_W           = 8,
   parameter int SUB_LOG2         = 14,
   parameter int SEG_LOG2         = 16,
   parameter int LOW_BASE         = 'hA0000,
   parameter int LOW_LOG2         = 17,
   parameter int MAIN_BASE        = 'hC0000,
   parameter int MAIN_LOG2        = 18,
   parameter int IDX_ROM_EN       = 'h48,
   parameter int IDX_LOCK         = 'h49,
   parameter int IDX_SHADOW_BASE  = 'h4A,
   parameter bit ROM_SEL_ON_WRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_port,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cyc_valid,
   input  logic              cyc_wr,
   input  logic [ADDR_W-1:0] cyc_addr,
   output logic              rom_cs,
   output logic              dram_sel,
   output logic              wr_inhibit
);
   import smr_pkg::*;

   localparam int N_SUB_LOW     = 1 << (LOW_LOG2 - SUB_LOG2);
   localparam int N_SUB         = N_SUB_LOW + (1 << (MAIN_LOG2 - SUB_LOG2));
   localparam int SUB_W         = $clog2(N_SUB);
   localparam int N_LOW_SEG     = 1 << (LOW_LOG2 - SEG_LOG2);
   localparam int N_ROM_SEG     = 1 << (MAIN_LOG2 - SEG_LOG2);
   localparam int N_SEG         = N_LOW_SEG + N_ROM_SEG;
   localparam int SEG_W         = $clog2(N_SEG);
   localparam int N_SHADOW_REGS = N_SUB / DATA_W;
   localparam int LOW_TOP       = LOW_BASE + (1 << LOW_LOG2);
   localparam int MAIN_TOP      = MAIN_BASE + (1 << MAIN_LOG2);

   if ((N_SUB % DATA_W) != 0) begin : g_bad_pack
      $error("shadow_region_mapper: sub-regions must fill whole shadow registers");
   end
   if (ADDR_W < MAIN_LOG2 + 1) begin : g_bad_addr_w
      $error("shadow_region_mapper: address too narrow for windows");
   end

   logic [N_ROM_SEG-1:0] rom_en;
   logic [N_SEG-1:0]     ro_lock;
   logic [N_SUB-1:0]     shadow_en;
   window_hit_t          hit;
   logic [SUB_W-1:0]     sub_idx;
   logic [SEG_W-1:0]     seg_idx;

   smr_cfg_regs #(
      .IDX_W          (DATA_W),
      .DATA_W         (DATA_W),
      .IDX_ROM_EN     (IDX_ROM_EN),
      .IDX_LOCK       (IDX_LOCK),
      .IDX_SHADOW_BASE(IDX_SHADOW_BASE),
      .N_SHADOW_REGS  (N_SHADOW_REGS),
      .N_ROM_SEG      (N_ROM_SEG),
      .N_SEG          (N_SEG)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_port (cfg_port),
      .cfg_wdata(cfg_wdata),
      .rom_en   (rom_en),
      .ro_lock  (ro_lock),
      .shadow_en(shadow_en)
   );

   smr_addr_decode #(
      .ADDR_W   (ADDR_W),
      .SUB_LOG2 (SUB_LOG2),
      .SEG_LOG2 (SEG_LOG2),
      .LOW_BASE (LOW_BASE),
      .LOW_LOG2 (LOW_LOG2),
      .MAIN_BASE(MAIN_BASE),
      .MAIN_LOG2(MAIN_LOG2),
      .SUB_W    (SUB_W),
      .SEG_W    (SEG_W)
   ) u_dec (
      .addr   (cyc_addr),
      .hit    (hit),
      .sub_idx(sub_idx),
      .seg_idx(seg_idx)
   );

   smr_route #(
      .N_SUB           (N_SUB),
      .SUB_W           (SUB_W),
      .N_SEG           (N_SEG),
      .SEG_W           (SEG_W),
      .N_LOW_SEG       (N_LOW_SEG),
      .N_ROM_SEG       (N_ROM_SEG),
      .ROM_SEL_ON_WRITE(ROM_SEL_ON_WRITE)
   ) u_route (
      .cyc_valid (cyc_valid),
      .cyc_wr    (cyc_wr),
      .hit       (hit),
      .sub_idx   (sub_idx),
      .seg_idx   (seg_idx),
      .shadow_en (shadow_en),
      .ro_lock   (ro_lock),
      .rom_en    (rom_en),
      .rom_cs    (rom_cs),
      .dram_sel  (dram_sel),
      .wr_inhibit(wr_inhibit)
   );

   logic addr_low_win;
   logic addr_outside;
   assign addr_low_win = (cyc_addr >= ADDR_W'(LOW_BASE)) && (cyc_addr < ADDR_W'(LOW_TOP));
   assign addr_outside = (cyc_addr < ADDR_W'(LOW_BASE)) || (cyc_addr >= ADDR_W'(MAIN_TOP));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_valid |-> !(rom_cs || dram_sel || wr_inhibit));

   a_r2_outside_to_dram: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && addr_outside) |-> (dram_sel && !rom_cs && !wr_inhibit));

   a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_cs && dram_sel));

   a_r6_low_never_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && addr_low_win) |-> !rom_cs);

   a_r7_inhibit_on_dram_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inhibit |-> (cyc_wr && dram_sel && !addr_outside));

endmodule

// File: tb/shadow_region_mapper_test.sv
`timescale 1ns/1ps
module shadow_region_mapper_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_port = 1'b0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic        cyc_valid = 1'b0;
   logic        cyc_wr = 1'b0;
   logic [23:0] cyc_addr = 24'h0;
   logic        rom_cs, dram_sel, wr_inhibit;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   shadow_region_mapper uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_port(cfg_port),
      .cfg_wdata(cfg_wdata), .cyc_valid(cyc_valid), .cyc_wr(cyc_wr),
      .cyc_addr(cyc_addr), .rom_cs(rom_cs), .dram_sel(dram_sel),
      .wr_inhibit(wr_inhibit)
   );

   // behavioural reference state
   bit [7:0]  m_idx;
   bit [3:0]  m_rom;
   bit [5:0]  m_lock;
   bit [23:0] m_sh;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_idx <= 8'h00; m_rom <= 4'hF; m_lock <= 6'h00; m_sh <= 24'h0;
      end else if (cfg_wr) begin
         if (!cfg_port) m_idx <= cfg_wdata;
         else begin
            case (m_idx)
               8'h48: m_rom <= cfg_wdata[3:0];
               8'h49: m_lock <= cfg_wdata[5:0];
               8'h4A: m_sh[7:0] <= cfg_wdata;
               8'h4B: m_sh[15:8] <= cfg_wdata;
               8'h4C: m_sh[23:16] <= cfg_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic model(output bit er, output bit ed, output bit ei, output string tag);
      int a, sub, seg;
      bit lo, mn;
      a = int'(cyc_addr);
      er = 0; ed = 0; ei = 0;
      lo = (a >= 'hA0000) && (a < 'hC0000);
      mn = (a >= 'hC0000) && (a < 'h100000);
      if (!cyc_valid) begin tag = "R11"; return; end
      if (!lo && !mn) begin ed = 1; tag = "R2"; return; end
      sub = (a - 'hA0000) / 'h4000;
      seg = sub / 4;
      if (m_sh[sub]) begin
         ed = 1; ei = cyc_wr && m_lock[seg]; tag = cyc_wr ? "R7" : "R5";
      end else if (mn && m_rom[seg-2]) begin
         er = 1; tag = "R3";
      end else begin
         tag = lo ? "R6" : "R4";
      end
   endtask

   task automatic compare(string req, bit er, bit ed, bit ei);
      checks++;
      if (rom_cs !== er || dram_sel !== ed || wr_inhibit !== ei) begin
         errors++;
         $display("FAIL %s addr=%h wr=%0b got rom=%0b dram=%0b inh=%0b expected rom=%0b dram=%0b inh=%0b",
                  req, cyc_addr, cyc_wr, rom_cs, dram_sel, wr_inhibit, er, ed, ei);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      bit er, ed, ei;
      string tag;
      #2;
      if (rst_n && !finished) begin
         model(er, ed, ei, tag);
         compare({tag, "-model"}, er, ed, ei);
      end
   end

   task automatic cfg(bit port, logic [7:0] d);
      @(negedge clk);
      cyc_valid = 0; cfg_wr = 1; cfg_port = port; cfg_wdata = d;
      @(posedge clk);
      #1 cfg_wr = 0;
   endtask

   task automatic set_reg(logic [7:0] idx, logic [7:0] d);
      cfg(1'b0, idx);
      cfg(1'b1, d);
   endtask

   task automatic bus(bit v, bit wr, logic [23:0] a, bit er, bit ed, bit ei, string req);
      @(negedge clk);
      cyc_valid = v; cyc_wr = wr; cyc_addr = a;
      #1 compare(req, er, ed, ei);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 / R11 reset state
      bus(0, 0, 24'h0F0000, 0, 0, 0, "R11");
      bus(1, 0, 24'h0FC000, 1, 0, 0, "R1");
      bus(1, 0, 24'h0A0000, 0, 0, 0, "R6");
      bus(1, 1, 24'h100000, 0, 1, 0, "R2");
      bus(1, 0, 24'h09FFFF, 0, 1, 0, "R2");
      bus(1, 1, 24'h0FC000, 1, 0, 0, "R3");
      // R5 / R10: shadow top sub-region, effective next cycle
      set_reg(8'h4C, 8'h80);
      bus(1, 0, 24'h0FC000, 0, 1, 0, "R10");
      bus(1, 0, 24'h0F8000, 1, 0, 0, "R3");
      bus(1, 0, 24'h0E0000, 1, 0, 0, "R3");
      // R4: ROM disabled
      set_reg(8'h48, 8'h00);
      bus(1, 0, 24'h0F0000, 0, 0, 0, "R4");
      bus(1, 0, 24'h0FFFFF, 0, 1, 0, "R5");
      // R5 / R6 lower window
      set_reg(8'h4A, 8'h01);
      bus(1, 0, 24'h0A0000, 0, 1, 0, "R5");
      bus(1, 0, 24'h0A4000, 0, 0, 0, "R6");
      // R7 / R8 lock all
      set_reg(8'h49, 8'h3F);
      bus(1, 1, 24'h0FC000, 0, 1, 1, "R7");
      bus(1, 0, 24'h0FC000, 0, 1, 0, "R7");
      bus(1, 1, 24'h0A0000, 0, 1, 1, "R7");
      bus(1, 1, 24'h0F0000, 0, 0, 0, "R8");
      set_reg(8'h48, 8'h0F);
      bus(1, 1, 24'h0C0000, 1, 0, 0, "R8");
      bus(1, 1, 24'h200000, 0, 1, 0, "R2");
      // R7 per-segment lock
      set_reg(8'h4C, 8'h81);
      set_reg(8'h49, 8'h20);
      bus(1, 1, 24'h0E0000, 0, 1, 0, "R7");
      bus(1, 1, 24'h0FC000, 0, 1, 1, "R7");
      set_reg(8'h49, 8'h00);
      bus(1, 1, 24'h0FC000, 0, 1, 0, "R10");
      // R9 foreign index and held index
      set_reg(8'h50, 8'hFF);
      bus(1, 0, 24'h0D0000, 1, 0, 0, "R9");
      cfg(1'b1, 8'h00);
      bus(1, 0, 24'h0D0000, 1, 0, 0, "R9");
      set_reg(8'h4B, 8'hFF);
      bus(1, 0, 24'h0D0000, 0, 1, 0, "R9");
      cfg(1'b1, 8'h00);
      bus(1, 0, 24'h0D0000, 1, 0, 0, "R9");
      bus(0, 1, 24'h0FC000, 0, 0, 0, "R11");
      @(negedge clk);
      @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule